// File: doc/BRIEF.md
# Multi-Channel Edge Timestamp Capture

This block timestamps transitions on up to four asynchronous input lines. A single free-running counter, advanced once every (prescale + 1) clock cycles, supplies the time base for all channels. Each channel has its own 2-bit edge mode. When a transition of the selected kind arrives, the channel copies the counter into its capture register and sets its pending flag. The pending flags are masked by per-channel interrupt enables, and the result drives one interrupt line. Software clears flags by writing an acknowledge word.

The edge mode encoding is chosen so that inverting both bits of a single-edge mode turns rising into falling and falling into rising. Software can therefore flip the mode after every event. It first timestamps the start of a high phase, then the start of the low phase, then the next rising edge, and derives period and duty from the differences. All register access goes through a simple word-addressed write strobe and a combinational read port.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, every register reads zero and `irq` is low. The registers are the control word, interrupt enables, pending flags, edge modes and capture values.
- R2: The edge mode is 2 bits. 00 ignores the input, 01 reacts to rising edges only, 10 reacts to falling edges only, and 11 reacts to both.
- R3: With the run bit set, the timestamp counter advances by one every (P+1) clock cycles, where P is the prescale field. Two events D·(P+1) cycles apart on two channels give captured values that differ by exactly D.
- R4: With the run bit clear, the counter holds its value. No input transition sets a flag or changes a capture register.
- R5: `irq` is high exactly when some channel has both its pending flag and its enable set. Clearing an enable does not clear the flag.
- R6: A write to the acknowledge word (offset 0x5C) clears the pending flag of channel i when data bit i+1 is 1. Other flags are left alone. Writing 0x1FF clears all flags.
- R7: If an acknowledge and a new event for the same channel occur in the same cycle, the flag stays set.
- R8: Register map. Capture value of channel i is at 0x10+4i. Edge mode of channel i is at 0x30+4i, in bits 1:0. Control is at 0x50: bit 10 is run and bits 8:4 are prescale, and all other bits read 0. Interrupt enables are at 0x54 and pending flags at 0x58, with channel i at bit i+1 in both.
- R9: XOR of a mode with 0b11 swaps rising-only and falling-only. After the swap, the channel reacts to the opposite edge only.
- R10: An input transition first shows in the pending flag after the third rising clock edge following the change. This latency comes from two synchroniser stages and one edge register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | NCH | Asynchronous capture inputs, one per channel |
| reg_addr | input | 8 | Byte address of the register access |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Combined masked interrupt |

## Verification
A wrong edge mode decode, or a lost or stuck flag, shows up in the flag register three clock edges after the input transition, and in `irq` in the same cycle when the channel is enabled. A timestamp counter that skips or stalls shows up only as a wrong difference between two capture registers. The bench therefore checks pairs of captures with exact spacing under two prescale settings. Ordering faults between acknowledge and event can only be seen by forcing them into one clock edge, and one scenario does exactly that.

// File: rtl/ecu_pkg.sv
package ecu_pkg;

  localparam logic [3:0] PAGE_CAP  = 4'h1;
  localparam logic [3:0] PAGE_MODE = 4'h3;
  localparam logic [3:0] PAGE_CFG  = 4'h5;

  localparam logic [3:0] CFG_CTRL  = 4'h0;
  localparam logic [3:0] CFG_IEN   = 4'h4;
  localparam logic [3:0] CFG_PEND  = 4'h8;
  localparam logic [3:0] CFG_ACK   = 4'hC;

  localparam int RUN_BIT = 10;
  localparam int PSC_LSB = 4;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  // mode bit 0 arms rising, bit 1 arms falling
  function automatic logic edge_hit(input logic [1:0] mode,
                                    input logic rise, input logic fall);
    return (mode[0] & rise) | (mode[1] & fall);
  endfunction

  // channel i sits at bit i+1 of the flag-style words
  function automatic logic [31:0] place_flags(input logic [3:0] v);
    return {27'd0, v, 1'b0};
  endfunction

endpackage

// File: rtl/ecu_sync_edge.sv
module ecu_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/ecu_timebase.sv
module ecu_timebase #(
  parameter int TS_W  = 32,
  parameter int PSC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  output logic [TS_W-1:0]  stamp,
  output logic             tick
);
  logic [PSC_W-1:0] div;

  assign tick = run && (div == psc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div   <= '0;
      stamp <= '0;
    end else begin
      if (!run || tick) div <= '0;
      else              div <= div + PSC_W'(1);
      if (tick) stamp <= stamp + TS_W'(1);
    end
  end
endmodule

// File: rtl/ecu_chan.sv
module ecu_chan
  import ecu_pkg::*;
#(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            din,
  input  logic            run,
  input  logic            mode_we,
  input  logic [1:0]      mode_wdata,
  input  logic            ack,
  input  logic [TS_W-1:0] stamp,
  output logic [1:0]      mode,
  output logic [TS_W-1:0] cap,
  output logic            pend,
  output logic            event_o
);
  logic rise, fall;

  ecu_sync_edge #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(din), .rise(rise), .fall(fall)
  );

  assign event_o = run && edge_hit(mode, rise, fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= EDGE_OFF;
      cap  <= '0;
      pend <= 1'b0;
    end else begin
      if (mode_we) mode <= mode_wdata;
      if (event_o) cap <= stamp;
      if (event_o)  pend <= 1'b1;
      else if (ack) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecu_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int TS_W  = 32,
  parameter int PSC_W = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] cap_in,
  input  logic [7:0]     reg_addr,
  input  logic           reg_we,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           irq
);
  logic             cap_on;
  logic [PSC_W-1:0] psc;
  logic [NCH-1:0]   ien;
  logic [TS_W-1:0]  stamp;
  logic             tick;
  logic [NCH-1:0]   ev_vec, st_vec, ack_vec, mode_we_vec;
  logic [1:0]       mode_arr [NCH];
  logic [TS_W-1:0]  cap_arr  [NCH];
  logic             wdata_unused;

  wire [3:0] page = reg_addr[7:4];
  wire [3:0] slot = reg_addr[3:0];
  wire ctrl_we = reg_we && page == PAGE_CFG && slot == CFG_CTRL;
  wire ien_we  = reg_we && page == PAGE_CFG && slot == CFG_IEN;
  wire ack_we  = reg_we && page == PAGE_CFG && slot == CFG_ACK;

  assign wdata_unused = ^{reg_wdata[31:RUN_BIT+1], reg_addr[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_on <= 1'b0;
      psc    <= '0;
      ien    <= '0;
    end else begin
      if (ctrl_we) begin
        cap_on <= reg_wdata[RUN_BIT];
        psc    <= reg_wdata[PSC_LSB +: PSC_W];
      end
      if (ien_we) ien <= reg_wdata[NCH:1];
    end
  end

  ecu_timebase #(.TS_W(TS_W), .PSC_W(PSC_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(cap_on), .psc(psc),
    .stamp(stamp), .tick(tick)
  );

  assign ack_vec = {NCH{ack_we}} & reg_wdata[NCH:1];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign mode_we_vec[i] = reg_we && page == PAGE_MODE && slot[3:2] == i[1:0];
    ecu_chan #(.TS_W(TS_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .din(cap_in[i]), .run(cap_on),
      .mode_we(mode_we_vec[i]), .mode_wdata(reg_wdata[1:0]),
      .ack(ack_vec[i]), .stamp(stamp),
      .mode(mode_arr[i]), .cap(cap_arr[i]), .pend(st_vec[i]),
      .event_o(ev_vec[i])
    );
  end

  assign irq = |(st_vec & ien);

  always_comb begin
    reg_rdata = '0;
    unique case (page)
      PAGE_CAP: begin
        for (int i = 0; i < NCH; i++)
          if (slot[3:2] == i[1:0]) reg_rdata[TS_W-1:0] = cap_arr[i];
      end
      PAGE_MODE: begin
        for (int i = 0; i < NCH; i++)
          if (slot[3:2] == i[1:0]) reg_rdata[1:0] = mode_arr[i];
      end
      PAGE_CFG: begin
        unique case (slot)
          CFG_CTRL: begin
            reg_rdata[RUN_BIT]           = cap_on;
            reg_rdata[PSC_LSB +: PSC_W]  = psc;
          end
          CFG_IEN:  reg_rdata = place_flags(4'(ien));
          CFG_PEND: reg_rdata = place_flags(4'(st_vec));
          default:  reg_rdata = '0;
        endcase
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ecu_chk.sv
module ecu_chk #(
  parameter int NCH  = 4,
  parameter int TS_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cap_on,
  input logic [TS_W-1:0] stamp,
  input logic [NCH-1:0]  ev,
  input logic [NCH-1:0]  st,
  input logic [NCH-1:0]  ack,
  input logic [NCH-1:0]  ien,
  input logic            irq
);
  // R4
  stamp_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cap_on) |-> $stable(stamp));

  // R4
  ev_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |-> cap_on);

  // R3
  stamp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_on |=> (stamp == $past(stamp) || stamp == $past(stamp) + TS_W'(1)));

  // R5
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(st & ~ack)) |=> ((st & $past(st & ~ack)) == $past(st & ~ack)));

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack & ~ev)) |=> ((st & $past(ack & ~ev)) == '0));

  // R7
  ev_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((st & $past(ev)) == $past(ev)));

  // R5
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);
endmodule

bind edge_capture_unit ecu_chk #(.NCH(NCH), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_on(cap_on), .stamp(stamp),
  .ev(ev_vec), .st(st_vec), .ack(ack_vec), .ien(ien), .irq(irq)
);

// File: tb/edge_capture_unit_tb.sv
module edge_capture_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  cin;
  logic [7:0]  addr;
  logic        we;
  logic [31:0] wd;
  wire  [31:0] rd;
  wire         irq;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  edge_capture_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cap_in(cin), .reg_addr(addr),
    .reg_we(we), .reg_wdata(wd), .reg_rdata(rd), .irq(irq)
  );

  localparam logic [7:0] A_CTRL = 8'h50, A_IEN = 8'h54,
                         A_PEND = 8'h58, A_ACK = 8'h5C;

  function automatic logic [7:0] a_cap(int ch);  return 8'(8'h10 + 4*ch); endfunction
  function automatic logic [7:0] a_mode(int ch); return 8'(8'h30 + 4*ch); endfunction
  function automatic logic [31:0] fl(int ch);    return 32'(1) << (ch + 1); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wd = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rdv(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rd;
  endtask

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic set_in(int ch, logic v);
    @(negedge clk); cin[ch] = v;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rdv(A_CTRL, v); chk("R1 ctrl", v, 0);
    rdv(A_IEN, v);  chk("R1 ien", v, 0);
    rdv(A_PEND, v); chk("R1 pend", v, 0);
    rdv(a_mode(2), v); chk("R1 mode", v, 0);
    rdv(a_cap(3), v);  chk("R1 cap", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) wr(a_mode(i), 32'hFFFF_FFFC | i);
    for (int i = 0; i < 4; i++) begin rdv(a_mode(i), v); chk("R8 mode readback", v, i); end
    wr(A_CTRL, 32'hFFFF_FFFF); rdv(A_CTRL, v); chk("R8 ctrl fields", v, 32'h5F0);
    wr(A_CTRL, 0);
    wr(A_IEN, 32'hFFFF_FFFF); rdv(A_IEN, v); chk("R8 ien fields", v, 32'h1E);
    wr(A_IEN, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    wr(a_mode(0), 3);
    set_in(0, 1); idle(5); set_in(0, 0); idle(5);
    rdv(A_PEND, v);    chk("R4 no flag when stopped", v, 0);
    rdv(a_cap(0), v);  chk("R4 no capture when stopped", v, 0);
  endtask

  task automatic t_latency();
    logic [31:0] v;
    wr(a_mode(0), 1); wr(A_CTRL, 32'h400); wr(A_ACK, 32'h1FF);
    set_in(0, 1); idle(2);
    rdv(A_PEND, v); chk("R10 not yet after two edges", v, 0);
    idle(1);
    rdv(A_PEND, v); chk("R10 flag after third edge", v, fl(0));
    set_in(0, 0); idle(4); wr(A_ACK, 32'h1FF);
  endtask

  task automatic t_edges();
    logic [31:0] v;
    for (int m = 0; m < 4; m++) begin
      wr(a_mode(1), m); wr(A_ACK, 32'h1FF);
      set_in(1, 1); idle(4);
      rdv(A_PEND, v); chk("R2 rising response", v, m[0] ? fl(1) : 0);
      wr(A_ACK, 32'h1FF);
      set_in(1, 0); idle(4);
      rdv(A_PEND, v); chk("R2 falling response", v, m[1] ? fl(1) : 0);
      wr(A_ACK, 32'h1FF);
    end
    wr(a_mode(1), 0);
  endtask

  task automatic t_capture(int p, int d, int expd);
    logic [31:0] c2, c3;
    wr(A_CTRL, 32'h400 | (p << 4));
    wr(a_mode(2), 1); wr(a_mode(3), 1);
    set_in(2, 1); idle(d - 1); set_in(3, 1); idle(5);
    rdv(a_cap(2), c2); rdv(a_cap(3), c3);
    chk("R3 capture spacing", c3 - c2, expd);
    set_in(2, 0); set_in(3, 0); idle(4);
    wr(A_ACK, 32'h1FF);
  endtask

  task automatic t_swap();
    logic [31:0] v, m;
    wr(A_CTRL, 32'h400); wr(a_mode(0), 1);
    rdv(a_mode(0), m); wr(a_mode(0), m ^ 32'h3);
    rdv(a_mode(0), v); chk("R9 swapped mode", v, 2);
    wr(A_ACK, 32'h1FF);
    set_in(0, 1); idle(4); rdv(A_PEND, v); chk("R9 rising ignored after swap", v, 0);
    set_in(0, 0); idle(4); rdv(A_PEND, v); chk("R9 falling seen after swap", v, fl(0));
    wr(A_ACK, 32'h1FF); wr(a_mode(0), 0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(A_IEN, fl(0)); wr(a_mode(0), 1); wr(a_mode(1), 1);
    set_in(1, 1); idle(4); chk("R5 masked channel no irq", {31'd0, irq}, 0);
    set_in(0, 1); idle(4); chk("R5 enabled channel irq", {31'd0, irq}, 1);
    wr(A_IEN, 0); chk("R5 irq drops with enable", {31'd0, irq}, 0);
    rdv(A_PEND, v); chk("R5 flags persist", v, fl(0) | fl(1));
    wr(A_IEN, fl(0)); chk("R5 irq returns", {31'd0, irq}, 1);
    wr(A_ACK, fl(0)); chk("R6 irq cleared by ack", {31'd0, irq}, 0);
    rdv(A_PEND, v); chk("R6 selective ack", v, fl(1));
    wr(A_ACK, 32'h1FF); rdv(A_PEND, v); chk("R6 full ack", v, 0);
    set_in(0, 0); set_in(1, 0); idle(4); wr(A_IEN, 0);
  endtask

  task automatic t_race();
    logic [31:0] v;
    wr(a_mode(0), 3); wr(a_mode(1), 3);
    set_in(1, 1); idle(4); set_in(0, 1); idle(4);
    rdv(A_PEND, v); chk("R7 setup", v, fl(0) | fl(1));
    set_in(0, 0); idle(1); wr(A_ACK, 32'h1FF);
    rdv(A_PEND, v); chk("R7 event beats ack", v, fl(0));
    set_in(1, 0); idle(4); wr(A_ACK, 32'h1FF);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cin = '0; addr = '0; we = 1'b0; wd = '0;
    idle(3); rst_n = 1'b1; idle(1);
    t_reset();
    t_map();
    t_disabled();
    t_latency();
    t_edges();
    t_capture(0, 37, 37);
    t_capture(3, 40, 10);
    t_swap();
    t_irq();
    t_race();
    finish_run();
  end
endmodule